// File: doc/BRIEF.md
# Angle-Scheduled Output Pattern Sequencer

This block drives an output word whose bits change level at programmed shaft angles. A position counter upstream of it supplies the current angle count and a once-per-turn index pulse. The block keeps a separate event list for each revolution of a repeating cycle. Each list entry names an angle, a bit of the output word, and the level that bit takes when the shaft reaches that angle. The active list advances on every index pulse. After a programmable number of revolutions it returns to the first list, so a pattern that spans several turns repeats.

Software fills the table through a single-entry write port while the sequencer is disarmed. Raising `arm` restarts the cycle at revolution 0 and clears the output word. While armed, a pointer walks the current revolution's list in slot order. Each entry fires once, when the angle input equals its stored angle. Consecutive entries that share an angle are gathered into one update of the output word. Every angle count lasts thousands of clocks, so this serial walk has ample time to finish.

Top module: `angle_pattern_seq`

## Requirements
- R1: After a synchronous reset, `patternOut` is 0, `revIdx` is 0, `wrRejected` is 0 and every table entry is invalid.
- R2: With `arm` low, a `wrEn` cycle stores `wrAngle`, `wrBit` (0 selects `patternOut[0]`, 15 selects `patternOut[15]`), `wrLevel` and `wrValid` into the slot `wrSlot` of the list for revolution `wrRev`. The stored entry is used after the next arm.
- R3: A `wrEn` cycle with `arm` high leaves the table unchanged. `wrRejected` is high for exactly the one cycle after it.
- R4: While armed, the list is walked from slot 0 in ascending slot order. The entry at the pointer fires when its valid flag is set and `angle` equals its stored angle; firing drives its bit to its level. The walk stops at the first invalid slot or after the last slot.
- R5: A run of k consecutive entries with the same angle updates `patternOut` once, on the (k+1)th rising edge after that angle is first presented. The run's effects appear together.
- R6: Within one revolution each entry fires at most once. Returning the angle to a value that has already fired causes no change.
- R7: An index pulse while armed moves `revIdx` to the next revolution, wrapping from `revLast` to 0. It restarts the walk at slot 0 and commits any effects already gathered.
- R8: On the first armed cycle after `arm` rises, `revIdx` and the pointer return to 0 and `patternOut` is cleared to 0.
- R9: While `arm` is low, `patternOut` and `revIdx` hold their values whatever `angle` and `indexPulse` do.
- R10: Each revolution uses only the entries stored under its own revolution number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arm | input | 1 | Sequencer enable; rising edge restarts the cycle |
| indexPulse | input | 1 | Once-per-revolution marker from the position counter |
| angle | input | ANGLE_W | Current angle count |
| revLast | input | REV_W | Number of revolutions in the cycle minus one |
| wrEn | input | 1 | Table write strobe |
| wrRev | input | REV_W | Revolution list being written |
| wrSlot | input | SLOT_W | Slot within that list |
| wrAngle | input | ANGLE_W | Angle at which the entry fires |
| wrBit | input | BIT_W | Output bit the entry drives |
| wrLevel | input | 1 | Level the bit takes |
| wrValid | input | 1 | Entry valid; clear marks the end of a list |
| patternOut | output | OUT_W | Registered output word |
| revIdx | output | REV_W | Current revolution number |
| wrRejected | output | 1 | One-cycle flag for a write made while armed |

## Verification
The bench builds the block with a 16-bit output word and 16-bit angles. It uses four revolution lists of eight slots each, and runs a three-revolution cycle. With only eight slots, one list can be filled to its last slot, which exercises the walk running off the end of a list. A three-revolution cycle that sits inside four lists exercises a wrap at `revLast` below the table's capacity. It also includes an empty list and a same-angle run of three entries. A behavioural model checks the cycle timing of the gathered update on every clock.

// File: rtl/angle_seq_pkg.sv
package angle_seq_pkg;

  // Per-cycle commands from the control to the datapath.
  typedef struct packed {
    logic clearAll;   // zero the shadow and output words
    logic applyEvt;   // apply the addressed entry to the shadow word
    logic commitOut;  // copy the shadow word to the output register
  } seqStrobe_t;

endpackage

// File: rtl/angle_seq_ctrl.sv
module angle_seq_ctrl
  import angle_seq_pkg::*;
#(
  parameter int MAX_REVS = 8,
  parameter int SLOTS    = 64,
  localparam int REV_W   = $clog2(MAX_REVS),
  localparam int SLOT_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              indexPulse,
  input  logic [REV_W-1:0]  revLast,
  input  logic              wrEn,
  input  logic              hit,
  output seqStrobe_t        strobe,
  output logic [REV_W-1:0]  rdRev,
  output logic [SLOT_W-1:0] rdSlot,
  output logic              wrAccept,
  output logic              wrRejected,
  output logic [REV_W-1:0]  revIdx
);

  localparam logic [SLOT_W:0] PtrEnd = (SLOT_W+1)'(SLOTS);

  logic              armedQ;
  logic [REV_W-1:0]  revQ;
  logic [SLOT_W:0]   ptrQ;
  logic              rejQ;
  logic              armRise;
  logic              active;
  logic              ptrLive;
  logic              takeHit;
  logic [REV_W-1:0]  revNext;

  assign armRise = arm && !armedQ;
  assign active  = arm && armedQ;
  assign ptrLive = (ptrQ < PtrEnd);
  assign takeHit = active && !indexPulse && ptrLive && hit;
  assign revNext = (revQ == revLast) ? '0 : revQ + REV_W'(1);

  // Commands for the datapath this cycle.
  always_comb begin
    strobe           = '0;
    strobe.clearAll  = armRise;
    strobe.applyEvt  = takeHit;
    strobe.commitOut = active && !takeHit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armedQ <= 1'b0;
      revQ   <= '0;
      ptrQ   <= '0;
      rejQ   <= 1'b0;
    end else begin
      armedQ <= arm;
      rejQ   <= wrEn && arm;
      if (armRise) begin
        revQ <= '0;
        ptrQ <= '0;
      end else if (active) begin
        if (indexPulse) begin
          revQ <= revNext;
          ptrQ <= '0;
        end else if (takeHit) begin
          ptrQ <= ptrQ + (SLOT_W+1)'(1);
        end
      end
    end
  end

  assign rdRev      = revQ;
  assign rdSlot     = ptrQ[SLOT_W-1:0];
  assign wrAccept   = wrEn && !arm;
  assign wrRejected = rejQ;
  assign revIdx     = revQ;

endmodule

// File: rtl/angle_seq_datapath.sv
module angle_seq_datapath
  import angle_seq_pkg::*;
#(
  parameter int OUT_W    = 16,
  parameter int ANGLE_W  = 16,
  parameter int MAX_REVS = 8,
  parameter int SLOTS    = 64,
  localparam int REV_W   = $clog2(MAX_REVS),
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int BIT_W   = $clog2(OUT_W),
  localparam int ADDR_W  = REV_W + SLOT_W,
  localparam int DEPTH   = MAX_REVS * SLOTS
) (
  input  logic               clk,
  input  logic               rst,
  input  seqStrobe_t         strobe,
  input  logic [REV_W-1:0]   rdRev,
  input  logic [SLOT_W-1:0]  rdSlot,
  input  logic [ANGLE_W-1:0] angle,
  input  logic               wrAccept,
  input  logic [REV_W-1:0]   wrRev,
  input  logic [SLOT_W-1:0]  wrSlot,
  input  logic [ANGLE_W-1:0] wrAngle,
  input  logic [BIT_W-1:0]   wrBit,
  input  logic               wrLevel,
  input  logic               wrValid,
  output logic               hit,
  output logic [OUT_W-1:0]   patternOut
);

  // Event table, one list of SLOTS entries per revolution.
  logic [ANGLE_W-1:0] tblAngle [DEPTH];
  logic [BIT_W-1:0]   tblBit   [DEPTH];
  logic               tblLevel [DEPTH];
  logic               tblValid [DEPTH];

  logic [ADDR_W-1:0]  rdAddr;
  logic [ADDR_W-1:0]  wrAddr;
  logic [BIT_W-1:0]   evBit;
  logic               evLevel;
  logic [OUT_W-1:0]   shadow;
  logic [OUT_W-1:0]   outQ;

  assign rdAddr = {rdRev, rdSlot};
  assign wrAddr = {wrRev, wrSlot};

  always_ff @(posedge clk) begin
    if (wrAccept) begin
      tblAngle[wrAddr] <= wrAngle;
      tblBit[wrAddr]   <= wrBit;
      tblLevel[wrAddr] <= wrLevel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tblValid[i] <= 1'b0;
    end else if (wrAccept) begin
      tblValid[wrAddr] <= wrValid;
    end
  end

  // Compare of the entry at the walk pointer.
  assign evBit   = tblBit[rdAddr];
  assign evLevel = tblLevel[rdAddr];
  assign hit     = tblValid[rdAddr] && (tblAngle[rdAddr] == angle);

  // Shadow word: gathers a run of same-angle events before commit.
  for (genvar g = 0; g < OUT_W; g++) begin : gShadow
    logic bitQ;
    always_ff @(posedge clk) begin
      if (rst || strobe.clearAll) begin
        bitQ <= 1'b0;
      end else if (strobe.applyEvt && (evBit == BIT_W'(g))) begin
        bitQ <= evLevel;
      end
    end
    assign shadow[g] = bitQ;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clearAll) begin
      outQ <= '0;
    end else if (strobe.commitOut) begin
      outQ <= shadow;
    end
  end

  assign patternOut = outQ;

endmodule

// File: rtl/angle_pattern_seq.sv
module angle_pattern_seq
  import angle_seq_pkg::*;
#(
  parameter int OUT_W    = 16,
  parameter int ANGLE_W  = 16,
  parameter int MAX_REVS = 8,
  parameter int SLOTS    = 64,
  localparam int REV_W   = $clog2(MAX_REVS),
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int BIT_W   = $clog2(OUT_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arm,
  input  logic               indexPulse,
  input  logic [ANGLE_W-1:0] angle,
  input  logic [REV_W-1:0]   revLast,
  input  logic               wrEn,
  input  logic [REV_W-1:0]   wrRev,
  input  logic [SLOT_W-1:0]  wrSlot,
  input  logic [ANGLE_W-1:0] wrAngle,
  input  logic [BIT_W-1:0]   wrBit,
  input  logic               wrLevel,
  input  logic               wrValid,
  output logic [OUT_W-1:0]   patternOut,
  output logic [REV_W-1:0]   revIdx,
  output logic               wrRejected
);

  seqStrobe_t        strobe;
  logic [REV_W-1:0]  rdRev;
  logic [SLOT_W-1:0] rdSlot;
  logic              wrAccept;
  logic              hit;

  angle_seq_ctrl #(
    .MAX_REVS(MAX_REVS),
    .SLOTS   (SLOTS)
  ) ctrl (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm),
    .indexPulse(indexPulse),
    .revLast   (revLast),
    .wrEn      (wrEn),
    .hit       (hit),
    .strobe    (strobe),
    .rdRev     (rdRev),
    .rdSlot    (rdSlot),
    .wrAccept  (wrAccept),
    .wrRejected(wrRejected),
    .revIdx    (revIdx)
  );

  angle_seq_datapath #(
    .OUT_W   (OUT_W),
    .ANGLE_W (ANGLE_W),
    .MAX_REVS(MAX_REVS),
    .SLOTS   (SLOTS)
  ) dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .rdRev     (rdRev),
    .rdSlot    (rdSlot),
    .angle     (angle),
    .wrAccept  (wrAccept),
    .wrRev     (wrRev),
    .wrSlot    (wrSlot),
    .wrAngle   (wrAngle),
    .wrBit     (wrBit),
    .wrLevel   (wrLevel),
    .wrValid   (wrValid),
    .hit       (hit),
    .patternOut(patternOut)
  );

endmodule

// File: rtl/angle_pattern_seq_chk.sv
module angle_pattern_seq_chk #(
  parameter int OUT_W    = 16,
  parameter int MAX_REVS = 8,
  localparam int REV_W   = $clog2(MAX_REVS)
) (
  input logic             clk,
  input logic             rst,
  input logic             arm,
  input logic             indexPulse,
  input logic [REV_W-1:0] revLast,
  input logic             wrEn,
  input logic [OUT_W-1:0] patternOut,
  input logic [REV_W-1:0] revIdx,
  input logic             wrRejected
);

  // R3
  rej_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && arm) |=> wrRejected);

  // R3
  rej_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (wrRejected && !$past(rst)) |-> $past(wrEn && arm));

  // R9
  hold_disarmed_chk: assert property (@(posedge clk) disable iff (rst)
    !arm |=> ($stable(patternOut) && $stable(revIdx)));

  // R8
  arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(arm) |=> (patternOut == '0 && revIdx == '0));

  // R7
  rev_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (arm && $past(arm) && !$past(rst) && indexPulse && revIdx == revLast)
      |=> revIdx == '0);

  // R7
  rev_step_chk: assert property (@(posedge clk) disable iff (rst)
    (arm && $past(arm) && !$past(rst) && indexPulse && revIdx != revLast)
      |=> revIdx == $past(revIdx) + REV_W'(1));

endmodule

bind angle_pattern_seq angle_pattern_seq_chk #(
  .OUT_W   (OUT_W),
  .MAX_REVS(MAX_REVS)
) chk (
  .clk       (clk),
  .rst       (rst),
  .arm       (arm),
  .indexPulse(indexPulse),
  .revLast   (revLast),
  .wrEn      (wrEn),
  .patternOut(patternOut),
  .revIdx    (revIdx),
  .wrRejected(wrRejected)
);

// File: tb/angle_pattern_seq_test.sv
`timescale 1ns/1ps
module angle_pattern_seq_test;

  localparam int OUT_W    = 16;
  localparam int ANGLE_W  = 16;
  localparam int MAX_REVS = 4;
  localparam int SLOTS    = 8;
  localparam int REV_W    = $clog2(MAX_REVS);
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int BIT_W    = $clog2(OUT_W);
  localparam int HOLD     = 12;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               arm = 1'b0;
  logic               indexPulse = 1'b0;
  logic [ANGLE_W-1:0] angle = '0;
  logic [REV_W-1:0]   revLast = REV_W'(2);
  logic               wrEn = 1'b0;
  logic [REV_W-1:0]   wrRev = '0;
  logic [SLOT_W-1:0]  wrSlot = '0;
  logic [ANGLE_W-1:0] wrAngle = '0;
  logic [BIT_W-1:0]   wrBit = '0;
  logic               wrLevel = 1'b0;
  logic               wrValid = 1'b0;
  logic [OUT_W-1:0]   patternOut;
  logic [REV_W-1:0]   revIdx;
  logic               wrRejected;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  angle_pattern_seq #(
    .OUT_W(OUT_W), .ANGLE_W(ANGLE_W), .MAX_REVS(MAX_REVS), .SLOTS(SLOTS)
  ) uut (
    .clk(clk), .rst(rst), .arm(arm), .indexPulse(indexPulse), .angle(angle),
    .revLast(revLast), .wrEn(wrEn), .wrRev(wrRev), .wrSlot(wrSlot),
    .wrAngle(wrAngle), .wrBit(wrBit), .wrLevel(wrLevel), .wrValid(wrValid),
    .patternOut(patternOut), .revIdx(revIdx), .wrRejected(wrRejected)
  );

  // Behavioural reference model
  int mAng [MAX_REVS][SLOTS];
  int mBit [MAX_REVS][SLOTS];
  int mLvl [MAX_REVS][SLOTS];
  bit mVal [MAX_REVS][SLOTS];
  int mRev = 0;
  int mPtr = 0;
  int mOut = 0;
  int mShadow = 0;
  bit mArmedPrev = 0;
  bit mRej = 0;

  always @(posedge clk) begin
    if (rst) begin
      mRev = 0; mPtr = 0; mOut = 0; mShadow = 0; mArmedPrev = 0; mRej = 0;
      for (int r = 0; r < MAX_REVS; r++)
        for (int s = 0; s < SLOTS; s++) mVal[r][s] = 0;
    end else begin
      bit rising;
      bit running;
      rising  = arm && !mArmedPrev;
      running = arm && mArmedPrev;
      mArmedPrev = arm;
      mRej = wrEn && arm;
      if (rising) begin
        mRev = 0; mPtr = 0; mOut = 0; mShadow = 0;
      end else if (running) begin
        if (indexPulse) begin
          mOut = mShadow;
          mRev = (mRev == int'(revLast)) ? 0 : mRev + 1;
          mPtr = 0;
        end else if (mPtr < SLOTS && mVal[mRev][mPtr] && mAng[mRev][mPtr] == int'(angle)) begin
          if (mLvl[mRev][mPtr] != 0) mShadow = mShadow | (1 << mBit[mRev][mPtr]);
          else mShadow = mShadow & ~(1 << mBit[mRev][mPtr]);
          mPtr++;
        end else begin
          mOut = mShadow;
        end
      end
      if (wrEn && !arm) begin
        mAng[wrRev][wrSlot] = int'(wrAngle);
        mBit[wrRev][wrSlot] = int'(wrBit);
        mLvl[wrRev][wrSlot] = int'(wrLevel);
        mVal[wrRev][wrSlot] = wrValid;
      end
    end
  end

  // Per-clock comparison against the model (R4, R5, R6, R7, R10 timing)
  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      if (int'(patternOut) != mOut || int'(revIdx) != mRev || wrRejected != mRej) begin
        fails++;
        $display("FAIL R4 per-clock model: out=%h rev=%0d rej=%0b expected out=%h rev=%0d rej=%0b",
                 patternOut, revIdx, wrRejected, mOut[OUT_W-1:0], mRev, mRej);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input int r, input int s, input int a, input int b, input int l, input bit v);
    @(negedge clk);
    wrEn = 1'b1; wrRev = REV_W'(r); wrSlot = SLOT_W'(s);
    wrAngle = ANGLE_W'(a); wrBit = BIT_W'(b); wrLevel = l[0]; wrValid = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sweep(input int from, input int upto);
    for (int a = from; a <= upto; a++) begin
      angle = ANGLE_W'(a);
      repeat (HOLD) @(negedge clk);
    end
  endtask

  task automatic pulseIndex();
    indexPulse = 1'b1;
    @(negedge clk);
    indexPulse = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(patternOut == '0, "R1 reset output", int'(patternOut), 0);
    check(revIdx == '0, "R1 reset revIdx", int'(revIdx), 0);
    check(wrRejected == 1'b0, "R1 reset flag", int'(wrRejected), 0);

    // Revolution 0: single event, a same-angle run of three, a late event
    put(0, 0, 10, 3, 1, 1);
    put(0, 1, 20, 5, 1, 1);
    put(0, 2, 20, 7, 1, 1);
    put(0, 3, 20, 3, 0, 1);
    put(0, 4, 30, 15, 1, 1);
    put(0, 5, 0, 0, 0, 0);
    // Revolution 1: list filled to its last slot
    put(1, 0, 5, 0, 1, 1);
    put(1, 1, 6, 1, 1, 1);
    put(1, 2, 7, 2, 1, 1);
    put(1, 3, 8, 15, 0, 1);
    put(1, 4, 9, 1, 0, 1);
    put(1, 5, 10, 4, 1, 1);
    put(1, 6, 11, 5, 0, 1);
    put(1, 7, 12, 0, 0, 1);
    // Revolution 2 left empty; revolution 3 holds a decoy outside the cycle
    put(3, 0, 3, 9, 1, 1);

    angle = '0;
    @(negedge clk);
    arm = 1'b1;
    @(negedge clk);

    // R3: write while armed is flagged and ignored
    wrEn = 1'b1; wrRev = '0; wrSlot = SLOT_W'(5);
    wrAngle = ANGLE_W'(35); wrBit = '0; wrLevel = 1'b1; wrValid = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check(wrRejected == 1'b1, "R3 reject flag", int'(wrRejected), 1);
    @(negedge clk);
    check(wrRejected == 1'b0, "R3 flag lasts one cycle", int'(wrRejected), 0);

    sweep(0, 19);
    check(patternOut == 16'h0008, "R4 single event", int'(patternOut), 16'h0008);

    // R5: three events at angle 20 land together after four edges
    angle = ANGLE_W'(20);
    repeat (3) @(negedge clk);
    check(patternOut == 16'h0008, "R5 run not yet committed", int'(patternOut), 16'h0008);
    @(negedge clk);
    check(patternOut == 16'h00A0, "R5 run committed together", int'(patternOut), 16'h00A0);

    sweep(21, 30);
    check(patternOut == 16'h80A0, "R4 later event", int'(patternOut), 16'h80A0);

    // R6: revisiting angles that already fired changes nothing
    sweep(10, 10);
    sweep(20, 20);
    sweep(30, 36);
    check(patternOut == 16'h80A0, "R6 no refire", int'(patternOut), 16'h80A0);
    check(patternOut[0] == 1'b0, "R3 rejected entry absent", int'(patternOut[0]), 0);

    // R7 / R10: revolution 1 list, walked to its last slot
    pulseIndex();
    check(revIdx == REV_W'(1), "R7 step to rev 1", int'(revIdx), 1);
    sweep(0, 15);
    check(patternOut == 16'h0094, "R10 rev 1 list", int'(patternOut), 16'h0094);

    pulseIndex();
    check(revIdx == REV_W'(2), "R7 step to rev 2", int'(revIdx), 2);
    sweep(0, 12);
    check(patternOut == 16'h0094, "R10 empty rev 2", int'(patternOut), 16'h0094);

    pulseIndex();
    check(revIdx == '0, "R7 wrap at revLast", int'(revIdx), 0);
    sweep(0, 12);
    check(patternOut == 16'h009C, "R7 walk restarts at slot 0", int'(patternOut), 16'h009C);

    // R9: disarmed block holds; R2 write accepted while disarmed
    arm = 1'b0;
    @(negedge clk);
    put(0, 5, 35, 0, 1, 1);
    check(wrRejected == 1'b0, "R2 disarmed write not flagged", int'(wrRejected), 0);
    sweep(0, 40);
    pulseIndex();
    check(patternOut == 16'h009C, "R9 output held", int'(patternOut), 16'h009C);
    check(revIdx == '0, "R9 revIdx held", int'(revIdx), 0);

    // R8: re-arm clears output and restarts the cycle
    angle = '0;
    @(negedge clk);
    arm = 1'b1;
    @(negedge clk);
    check(patternOut == '0, "R8 output cleared", int'(patternOut), 0);
    check(revIdx == '0, "R8 rev restarted", int'(revIdx), 0);
    sweep(0, 36);
    check(patternOut == 16'h80A1, "R2 new entry fires", int'(patternOut), 16'h80A1);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule